// File: doc/BRIEF.md
# Colour Palette Loader with Lookup Port

This block holds a 256-entry colour look-up table. Each entry is an 8-bit red, green and blue triple. A host loads it through a 16-byte register window that has two live words. One word selects the entry to write. The other word is a shared data port. Writes to the data port fill red, then green, then blue of the selected entry. After the blue write the selection moves on to the next entry, so a stream of triples loads a run of consecutive entries. Every component value is carried in the most significant byte of the 32-bit bus word.

A pixel pipeline reads the table through a separate lookup port. It presents an entry number and gets back that entry's red, green and blue one clock later. Each component written by the host shows on this port as soon as it is written; the port does not wait for the whole triple. Reads of the register window always return zero. On reset the table is all black except the last entry, which is white.

Top module: `palette_dac`

## Requirements
- R1: An accepted write to the select word (wr_addr[3:2] = 0) loads the entry number from wr_data[31:24] and returns the component sequence to red.
- R2: An accepted write to the data word (wr_addr[3:2] = 1) stores wr_data[31:24] into the selected entry. The first such write goes to red, the second to green and the third to blue.
- R3: The write that stores blue also advances the entry number by one, modulo 256 (255 is followed by 0), and returns the sequence to red.
- R4: A component written on one clock edge is returned by a lookup that is presented after that edge. Lookups see single components before the rest of the triple is written.
- R5: The lookup port samples lk_idx on a clock edge and presents {lk_red, lk_green, lk_blue} after that edge. If a write to the same entry lands on the same edge, the lookup returns the value from before the write.
- R6: rd_data is always zero.
- R7: A write is accepted only when wr_strb = 4'b1111, wr_addr[1:0] = 0 and wr_addr[3:2] is 0 or 1. Any other write leaves the entry number, the component sequence and all entries unchanged.
- R8: After reset, entries 0 to 254 are (0,0,0) and entry 255 is (255,255,255). The entry number is 0 and the sequence starts at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 4 | Byte address within the register window |
| wr_strb | input | 4 | Byte enables; only all ones is a valid access |
| wr_data | input | 32 | Write data; the value is in bits 31:24 |
| rd_data | output | 32 | Register read data, always zero |
| lk_idx | input | 8 | Entry number for the lookup port |
| lk_red | output | 8 | Red of the entry looked up one cycle earlier |
| lk_green | output | 8 | Green of the entry looked up one cycle earlier |
| lk_blue | output | 8 | Blue of the entry looked up one cycle earlier |

## Verification
The hardest situation to reach from the ports is an entry-select write that arrives in the middle of a triple, together with the wrap from entry 255 to entry 0. Both depend on hidden sequence state that shows only in where later data writes land. The bench loads all 256 entries with computed triples, which carries the entry number across the wrap. It then writes one more red and checks that the value landed in entry 0. It cuts triples short with select writes and sends malformed writes between the components of a triple. For each case it confirms, through the lookup port, which entry and component the next data write reached.

// File: rtl/palette_pkg.sv
`timescale 1ns/1ps
package palette_pkg;
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;
endpackage

// File: rtl/palette_regif.sv
`timescale 1ns/1ps
module palette_regif
    import palette_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W/8-1:0]  wr_strb,
    input  logic [BUS_W-1:0]    wr_data,
    output logic                upd_valid,
    output logic [IDX_W-1:0]    upd_idx,
    output phase_e              upd_sel,
    output logic [COMP_W-1:0]   upd_val
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int LOW_W  = BUS_W - COMP_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           phase;
    } seq_t;

    seq_t st_d, st_q;
    logic hit_idx, hit_dat;
    logic [WORD_W-1:0] word;
    logic unused_low;

    assign unused_low = ^wr_data[LOW_W-1:0];
    assign word       = wr_addr[ADDR_W-1:2];

    always_comb begin
        logic accept;
        accept  = wr_en && (wr_addr[1:0] == 2'b00) && (&wr_strb);
        hit_idx = accept && (word == WORD_W'(0));
        hit_dat = accept && (word == WORD_W'(1));

        st_d = st_q;
        if (hit_idx) begin
            st_d.idx   = wr_data[BUS_W-1 -: IDX_W];
            st_d.phase = PH_RED;
        end else if (hit_dat) begin
            case (st_q.phase)
                PH_RED:   st_d.phase = PH_GREEN;
                PH_GREEN: st_d.phase = PH_BLUE;
                default: begin
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + 1'b1;
                end
            endcase
        end

        upd_valid = hit_dat;
        upd_idx   = st_q.idx;
        upd_sel   = st_q.phase;
        upd_val   = wr_data[BUS_W-1 -: COMP_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, phase: PH_RED};
        end else begin
            st_q <= st_d;
        end
    end

    p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_idx |=> (st_q.idx == $past(wr_data[BUS_W-1 -: IDX_W])) && (st_q.phase == PH_RED));

    p_red_to_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dat && st_q.phase == PH_RED) |=> (st_q.phase == PH_GREEN) && $stable(st_q.idx));

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dat && st_q.phase == PH_BLUE) |=>
            (st_q.phase == PH_RED) && (st_q.idx == IDX_W'($past(st_q.idx) + 1'b1)));

    p_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_idx && !hit_dat) |=> $stable(st_q));
endmodule

// File: rtl/palette_store.sv
`timescale 1ns/1ps
module palette_store
    import palette_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    input  logic [IDX_W-1:0]      upd_idx,
    input  phase_e                upd_sel,
    input  logic [COMP_W-1:0]     upd_val,
    input  logic [IDX_W-1:0]      lk_idx,
    output logic [3*COMP_W-1:0]   lk_rgb
);
    localparam int N     = 1 << IDX_W;
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] ent_d [N];
    logic [RGB_W-1:0] ent_q [N];
    logic [RGB_W-1:0] rd_d, rd_q;

    function automatic logic [COMP_W-1:0] comp_of(logic [RGB_W-1:0] v, phase_e s);
        case (s)
            PH_RED:   return v[RGB_W-1 -: COMP_W];
            PH_GREEN: return v[2*COMP_W-1 -: COMP_W];
            default:  return v[COMP_W-1:0];
        endcase
    endfunction

    always_comb begin
        for (int e = 0; e < N; e++) begin
            ent_d[e] = ent_q[e];
        end
        if (upd_valid) begin
            case (upd_sel)
                PH_RED:   ent_d[upd_idx][RGB_W-1 -: COMP_W]    = upd_val;
                PH_GREEN: ent_d[upd_idx][2*COMP_W-1 -: COMP_W] = upd_val;
                default:  ent_d[upd_idx][COMP_W-1:0]           = upd_val;
            endcase
        end
        rd_d = ent_q[lk_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N; e++) begin
                ent_q[e] <= (e == N - 1) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
            end
            rd_q <= '0;
        end else begin
            for (int e = 0; e < N; e++) begin
                ent_q[e] <= ent_d[e];
            end
            rd_q <= rd_d;
        end
    end

    assign lk_rgb = rd_q;

    p_update_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> comp_of(ent_q[$past(upd_idx)], $past(upd_sel)) == $past(upd_val));
endmodule

// File: rtl/palette_dac.sv
`timescale 1ns/1ps
module palette_dac
    import palette_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W/8-1:0]  wr_strb,
    input  logic [BUS_W-1:0]    wr_data,
    output logic [BUS_W-1:0]    rd_data,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [COMP_W-1:0]   lk_red,
    output logic [COMP_W-1:0]   lk_green,
    output logic [COMP_W-1:0]   lk_blue
);
    logic              upd_valid;
    logic [IDX_W-1:0]  upd_idx;
    phase_e            upd_sel;
    logic [COMP_W-1:0] upd_val;
    logic [3*COMP_W-1:0] lk_rgb;

    palette_regif #(
        .BUS_W(BUS_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .COMP_W(COMP_W)
    ) i_regif (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_sel(upd_sel), .upd_val(upd_val)
    );

    palette_store #(
        .IDX_W(IDX_W), .COMP_W(COMP_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_sel(upd_sel), .upd_val(upd_val),
        .lk_idx(lk_idx), .lk_rgb(lk_rgb)
    );

    // R6: the register window reads as zero
    assign rd_data  = '0;
    assign lk_red   = lk_rgb[3*COMP_W-1 -: COMP_W];
    assign lk_green = lk_rgb[2*COMP_W-1 -: COMP_W];
    assign lk_blue  = lk_rgb[COMP_W-1:0];
endmodule

// File: tb/test_palette_dac.sv
`timescale 1ns/1ps
module test_palette_dac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  lk_idx = '0;
    logic [7:0]  lk_red, lk_green, lk_blue;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [23:0] exp_tab [256];
    logic [7:0]  m_idx;
    int          m_ph;

    always #2 clk = ~clk;

    palette_dac i_palette_dac (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_data(rd_data),
        .lk_idx(lk_idx), .lk_red(lk_red), .lk_green(lk_green), .lk_blue(lk_blue)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model of an accepted/ignored write, taken from R1, R2, R3, R7
    task automatic model_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [7:0] v;
        v = d[31:24];
        if (s == 4'hF && a[1:0] == 2'b00) begin
            if (a[3:2] == 2'd0) begin
                m_idx = v;
                m_ph  = 0;
            end else if (a[3:2] == 2'd1) begin
                if (m_ph == 0) exp_tab[m_idx][23:16] = v;
                else if (m_ph == 1) exp_tab[m_idx][15:8] = v;
                else exp_tab[m_idx][7:0] = v;
                if (m_ph == 2) begin
                    m_ph  = 0;
                    m_idx = m_idx + 8'd1;
                end else begin
                    m_ph = m_ph + 1;
                end
            end
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
        model_wr(a, d, s);
    endtask

    task automatic lookup(input logic [7:0] i, input string req);
        @(negedge clk);
        lk_idx = i;
        @(negedge clk);
        check({lk_red, lk_green, lk_blue} == exp_tab[i], req,
              {i, lk_red, lk_green, lk_blue}, {i, exp_tab[i]});
    endtask

    initial begin
        for (int e = 0; e < 256; e++) exp_tab[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
        m_idx = '0; m_ph = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset contents, full sweep
        check(rd_data == 32'h0, "R6 rdata after reset", rd_data, 32'h0);
        for (int e = 0; e < 256; e++) lookup(8'(e), "R8 reset contents");

        // R8 + R4: data writes with no select land in entry 0 from red
        bus_wr(4'h4, 32'hAB00_0000, 4'hF);
        lookup(8'd0, "R4 red visible alone, R8 reset index");
        bus_wr(4'h4, 32'hCD12_3456, 4'hF);
        lookup(8'd0, "R4 green visible");
        bus_wr(4'h4, 32'hEF00_00FF, 4'hF);
        lookup(8'd0, "R2 blue completes triple");
        bus_wr(4'h4, 32'h4200_0000, 4'hF);
        lookup(8'd1, "R3 advance to entry 1");
        check(rd_data == 32'h0, "R6 rdata idle", rd_data, 32'h0);

        // R2/R3: fill all entries from 0 with computed triples
        bus_wr(4'h0, 32'h0000_0000, 4'hF);
        for (int e = 0; e < 256; e++) begin
            logic [7:0] r, g, b;
            r = 8'(e * 7 + 3);
            g = 8'(e) ^ 8'h5C;
            b = 8'(255 - e * 3);
            bus_wr(4'h4, {r, 24'h0}, 4'hF);
            bus_wr(4'h4, {g, 24'h0}, 4'hF);
            bus_wr(4'h4, {b, 24'h0}, 4'hF);
        end
        for (int e = 0; e < 256; e++) lookup(8'(e), "R2 R3 full fill");
        // R3: index wrapped from 255 to 0
        bus_wr(4'h4, 32'h5A00_0000, 4'hF);
        lookup(8'd0, "R3 wrap 255 to 0");
        lookup(8'd255, "R3 wrap leaves 255");

        // R1: select write mid-triple restarts at red
        bus_wr(4'h0, 32'h1400_0000, 4'hF);
        bus_wr(4'h4, 32'h0100_0000, 4'hF);
        bus_wr(4'h4, 32'h0200_0000, 4'hF);
        bus_wr(4'h0, 32'h14FF_FFFF, 4'hF);
        bus_wr(4'h4, 32'h0300_0000, 4'hF);
        lookup(8'd20, "R1 select resets phase");
        bus_wr(4'h0, 32'hC800_0000, 4'hF);
        bus_wr(4'h4, 32'h3300_0000, 4'hF);
        lookup(8'd200, "R1 select loads bits 31:24");

        // R7: malformed writes ignored between components
        bus_wr(4'h0, 32'h2800_0000, 4'hF);
        bus_wr(4'h4, 32'h1000_0000, 4'hF);
        bus_wr(4'h8, 32'h9900_0000, 4'hF);
        bus_wr(4'hC, 32'h9900_0000, 4'hF);
        bus_wr(4'h5, 32'h9900_0000, 4'hF);
        bus_wr(4'h4, 32'h9900_0000, 4'h7);
        bus_wr(4'h0, 32'h9900_0000, 4'hE);
        bus_wr(4'h1, 32'h9900_0000, 4'hF);
        bus_wr(4'h4, 32'h2000_0000, 4'hF);
        lookup(8'd40, "R7 ignored writes keep phase and index");
        lookup(8'h99, "R7 ignored writes touch no entry");
        lookup(8'd41, "R7 neighbour untouched");

        // R5: lookup on the same edge as a write returns old value
        bus_wr(4'h0, 32'h3C00_0000, 4'hF);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'h4; wr_data = 32'h7700_0000; wr_strb = 4'hF;
        lk_idx = 8'd60;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
        check({lk_red, lk_green, lk_blue} == exp_tab[60], "R5 same-edge returns old",
              {8'd60, lk_red, lk_green, lk_blue}, {8'd60, exp_tab[60]});
        model_wr(4'h4, 32'h7700_0000, 4'hF);
        @(negedge clk);
        check({lk_red, lk_green, lk_blue} == exp_tab[60], "R5 next lookup returns new",
              {8'd60, lk_red, lk_green, lk_blue}, {8'd60, exp_tab[60]});
        check(rd_data == 32'h0, "R6 rdata at end", rd_data, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule